// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves a PLL to a new multiplier without glitching its output. A start pulse hands it the packed multiplier word already encoded for the PLL's divider register, the present value of the PLL's control register, an input frequency and a target frequency. The block first works out the requested multiplier. That multiplier is the input frequency divided by twice the target, rounded up. The block refuses any request it cannot serve. An accepted request then drives a fixed series of register writes through a valid/ready write port. The series stops the PLL, loads the multiplier and unity pre/post dividers, and restarts the PLL.

After restart the block counts microsecond ticks and samples the PLL's lock flag at fixed intervals. A lock turns the clock output back on and ends the run cleanly. Too many failed samples end the run with an error. The requested multiplier is reported beside the completion pulse so a caller can log it.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `wr_valid`, `done` and `error` are low and `mult` is zero.
- R2: A start with `fin` below `ftarget`, or with `ftarget` zero, issues no write and raises `done` and `error` together in the cycle after the start; `mult` then reads zero.
- R3: For other requests `mult` at `done` equals ceil(`fin` / (2 × `ftarget`)). A value above MULT_MAX (default 32768) ends the run with `done` and `error` and no write.
- R4: The first write goes to STAT_ADDR+4 and carries the captured control word with bit 0 (power-down) set and bits 1 to 4 (bypass, direct-in, direct-out, output-enable) cleared, all other bits unchanged.
- R5: The second write puts the multiplier word at STAT_ADDR+8. The third puts 0x00302062 (pre- and post-divider of one) at STAT_ADDR+12.
- R6: The fourth write goes to STAT_ADDR+4 with bits 0 to 4 of the captured control word all cleared.
- R7: Each write holds `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready`, and with `wr_ready` held high the writes follow in consecutive cycles.
- R8: `pll_lock` is sampled only in the cycle of every tenth `us_tick` counted after the fourth write is accepted. Ticks before that acceptance are not counted.
- R9: The first sample that sees lock high, if it is one of the first four, is followed next cycle by a fifth write to STAT_ADDR+4. That write sets bit 4 and clears bits 0 to 3 of the captured word, and the run ends with `done` and no `error`.
- R10: If none of the four samples sees lock, `done` and `error` rise in the cycle after the fourth sample, and no fifth write occurs.
- R11: A start while a run is active has no effect on that run or its written values.
- R12: `done` is a one-cycle pulse per run, and `error` is high only while `done` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reprogramming run (taken only when idle) |
| mdiv_word | input | 32 | Packed multiplier word for the PLL divider register |
| ctrl_now | input | 32 | Present value of the PLL control register |
| fin | input | FW | Input frequency |
| ftarget | input | FW | Target frequency |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| pll_lock | input | 1 | PLL lock status flag |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Write accepted in this cycle when high with `wr_valid` |
| wr_addr | output | AW | Register address of the write |
| wr_data | output | 32 | Register data of the write |
| done | output | 1 | Run complete, one cycle |
| error | output | 1 | Run failed, valid with `done` |
| mult | output | FW | Requested multiplier, valid with `done` |

## Verification
Two things can happen in the same cycle: the lock flag changing and the tick that triggers a sample. A tick can also arrive while a configuration write is still stalled. The bench keeps ticks running the whole time and stalls the write port on alternate cycles. It raises lock exactly in the cycle of the chosen tenth tick after the power-up write was accepted, so any tick counted early or late shifts the sample off the lock edge. It then checks the cycle in which the output-enable write or the error pulse appears against its own count of ticks.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIV,
    ST_PDN,
    ST_LDMUL,
    ST_LDNP,
    ST_PUP,
    ST_WAIT,
    ST_OUTEN,
    ST_FIN
  } seq_state_t;

  typedef logic [31:0] reg_word_t;

  // Control register bit positions decoded by the PLL
  localparam int CB_PWRDN = 0;
  localparam int CB_OUTEN = 4;
  localparam int CB_LOW_W = 5;

  // Offsets from the status register address
  localparam int OFS_CTRL = 4;
  localparam int OFS_MUL  = 8;
  localparam int OFS_NP   = 12;

  // Divider word giving pre- and post-division by one
  localparam reg_word_t NP_UNITY = 32'h0030_2062;

endpackage

// File: rtl/pll_seq_ceildiv.sv
module pll_seq_ceildiv #(
  parameter int NW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          fin_pulse,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [NW:0]   rem_q, rem_d;
  logic [NW-1:0] quo_q, quo_d;
  logic [NW-1:0] den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          fin_q, fin_d;
  logic [NW:0]   shifted;
  logic          fits;

  assign shifted = {rem_q[NW-1:0], quo_q[NW-1]};
  assign fits    = ({1'b0, den_q} <= shifted);

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (go) begin
      rem_d  = '0;
      quo_d  = num;
      den_d  = den;
      cnt_d  = CW'(NW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? (shifted - {1'b0, den_q}) : shifted;
      quo_d = {quo_q[NW-2:0], fits};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign fin_pulse = fin_q;
  assign quo       = quo_q;

  // R3: the divider is never restarted while a division is in flight
  assert_div_nostart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);

  // R3: the finish pulse lasts one cycle
  assert_div_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_pulse |=> !fin_pulse);

endmodule

// File: rtl/pll_seq_polltimer.sv
module pll_seq_polltimer #(
  parameter int WAIT_TICKS = 10,
  parameter int TRIES      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic sample,
  output logic last
);
  localparam int TW = $clog2(WAIT_TICKS + 1);
  localparam int RW = $clog2(TRIES + 1);

  logic [TW-1:0] tick_q, tick_d;
  logic [RW-1:0] try_q, try_d;
  logic          hit;

  assign hit    = run && tick && (tick_q == TW'(WAIT_TICKS - 1));
  assign sample = hit;
  assign last   = (try_q == RW'(TRIES - 1));

  always_comb begin
    tick_d = tick_q;
    try_d  = try_q;
    if (!run) begin
      tick_d = '0;
      try_d  = '0;
    end else if (tick) begin
      if (hit) begin
        tick_d = '0;
        try_d  = try_q + RW'(1);
      end else begin
        tick_d = tick_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      try_q  <= '0;
    end else begin
      tick_q <= tick_d;
      try_q  <= try_d;
    end
  end

  // R10: the sequencer leaves the poll phase before the attempt budget is exceeded
  assert_try_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (try_q < RW'(TRIES)));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int FW         = 32,
  parameter int AW         = 12,
  parameter int STAT_ADDR  = 'h100,
  parameter int MULT_MAX   = 32768,
  parameter int WAIT_TICKS = 10,
  parameter int TRIES      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   mdiv_word,
  input  logic [31:0]   ctrl_now,
  input  logic [FW-1:0] fin,
  input  logic [FW-1:0] ftarget,
  input  logic          us_tick,
  input  logic          pll_lock,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          done,
  output logic          error,
  output logic [FW-1:0] mult
);
  localparam int NW = FW + 2;
  localparam logic [AW-1:0] A_CTRL = AW'(STAT_ADDR + OFS_CTRL);
  localparam logic [AW-1:0] A_MUL  = AW'(STAT_ADDR + OFS_MUL);
  localparam logic [AW-1:0] A_NP   = AW'(STAT_ADDR + OFS_NP);

  seq_state_t    state_q, state_d;
  reg_word_t     ctrl_q, mdiv_q;
  logic          err_q, err_d;
  logic [FW-1:0] mult_q, mult_d;
  logic          cap_en;
  logic          freq_bad;
  logic          div_go, div_fin;
  logic [NW-1:0] div_num, div_den, div_quo;
  logic          poll_run, poll_sample, poll_last;
  logic [31-CB_LOW_W:0] ctrl_hi;

  assign freq_bad = (fin < ftarget) || (ftarget == '0);
  assign cap_en   = (state_q == ST_IDLE) && start;
  assign div_num  = NW'(fin) + (NW'(ftarget) << 1) - NW'(1);
  assign div_den  = NW'(ftarget) << 1;
  assign poll_run = (state_q == ST_WAIT);
  assign ctrl_hi  = ctrl_q[31:CB_LOW_W];

  pll_seq_ceildiv #(.NW(NW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (div_go),
    .num       (div_num),
    .den       (div_den),
    .fin_pulse (div_fin),
    .quo       (div_quo)
  );

  pll_seq_polltimer #(.WAIT_TICKS(WAIT_TICKS), .TRIES(TRIES)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (poll_run),
    .tick   (us_tick),
    .sample (poll_sample),
    .last   (poll_last)
  );

  // Write port: one request per write state
  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = A_CTRL;
    wr_data  = '0;
    unique case (state_q)
      ST_PDN: begin
        wr_valid = 1'b1;
        wr_data  = {ctrl_hi, 4'b0000, 1'b1};
      end
      ST_LDMUL: begin
        wr_valid = 1'b1;
        wr_addr  = A_MUL;
        wr_data  = mdiv_q;
      end
      ST_LDNP: begin
        wr_valid = 1'b1;
        wr_addr  = A_NP;
        wr_data  = NP_UNITY;
      end
      ST_PUP: begin
        wr_valid = 1'b1;
        wr_data  = {ctrl_hi, 5'b00000};
      end
      ST_OUTEN: begin
        wr_valid = 1'b1;
        wr_data  = {ctrl_hi, 1'b1, 4'b0000};
      end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    mult_d  = mult_q;
    div_go  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mult_d = '0;
          if (freq_bad) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            err_d   = 1'b0;
            div_go  = 1'b1;
            state_d = ST_DIV;
          end
        end
      end
      ST_DIV: begin
        if (div_fin) begin
          mult_d = div_quo[FW-1:0];
          if (div_quo > NW'(MULT_MAX)) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            state_d = ST_PDN;
          end
        end
      end
      ST_PDN:   if (wr_ready) state_d = ST_LDMUL;
      ST_LDMUL: if (wr_ready) state_d = ST_LDNP;
      ST_LDNP:  if (wr_ready) state_d = ST_PUP;
      ST_PUP:   if (wr_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (poll_sample) begin
          if (pll_lock) begin
            state_d = ST_OUTEN;
          end else if (poll_last) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end
        end
      end
      ST_OUTEN: if (wr_ready) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      mult_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      mult_q  <= mult_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mdiv_q <= '0;
    end else if (cap_en) begin
      ctrl_q <= ctrl_now;
      mdiv_q <= mdiv_word;
    end
  end

  assign done  = (state_q == ST_FIN);
  assign error = done && err_q;
  assign mult  = mult_q;

  // R7: a stalled write keeps its request, address and data
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R2: a frequency-illegal start finishes with an error on the next cycle
  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q == ST_IDLE) && (fin < ftarget)) |=> (done && error && !wr_valid));

  // R12: completion is a single-cycle pulse
  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: output enable is never written together with power-down
  assert_oe_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_addr == A_CTRL) && wr_data[CB_OUTEN]) |-> !wr_data[CB_PWRDN]);

endmodule

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 32;
  localparam int AW = 12;
  localparam int BASE = 'h100;
  localparam int WAITT = 10;
  localparam int TRIES = 4;
  localparam int TICK_GAP = 3;
  localparam int RUN_LIMIT = 3000;
  localparam logic [AW-1:0] A_CTRL = AW'(BASE + 4);
  localparam logic [AW-1:0] A_MUL  = AW'(BASE + 8);
  localparam logic [AW-1:0] A_NP   = AW'(BASE + 12);

  typedef struct packed {
    logic [31:0] fin;
    logic [31:0] ft;
    logic [31:0] ctrl;
    logic [31:0] mdiv;
    logic [3:0]  lock_at;
    logic        stall;
    logic        exp_err;
    logic [31:0] exp_mult;
    logic [3:0]  exp_nw;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'd480,        32'd40,         32'h0000_001E, 32'h0123_4567, 4'd1, 1'b0, 1'b0, 32'd6,          4'd5},
    '{32'd1000,       32'd3,          32'hA5A5_5A5F, 32'h0BAD_F00D, 4'd4, 1'b1, 1'b0, 32'd167,        4'd5},
    '{32'd100,        32'd100,        32'hFFFF_FFE0, 32'h0000_0001, 4'd2, 1'b0, 1'b0, 32'd1,          4'd5},
    '{32'd50,         32'd60,         32'h1234_5678, 32'h0000_0000, 4'd1, 1'b0, 1'b1, 32'd0,          4'd0},
    '{32'd100,        32'd0,          32'h1234_5678, 32'h0000_0000, 4'd1, 1'b0, 1'b1, 32'd0,          4'd0},
    '{32'd65536,      32'd1,          32'h0F0F_0F15, 32'hDEAD_BEEF, 4'd3, 1'b1, 1'b0, 32'd32768,      4'd5},
    '{32'd65537,      32'd1,          32'h0F0F_0F15, 32'hDEAD_BEEF, 4'd1, 1'b0, 1'b1, 32'd32769,      4'd0},
    '{32'd900,        32'd7,          32'h8000_0008, 32'h0000_4242, 4'd0, 1'b0, 1'b1, 32'd65,         4'd4},
    '{32'hFFFF_FFFF,  32'd1,          32'h0000_0000, 32'h0000_0000, 4'd1, 1'b0, 1'b1, 32'h8000_0000,  4'd0},
    '{32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'h7654_321F, 32'h0001_FFFF, 4'd1, 1'b1, 1'b0, 32'd1,          4'd5}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [31:0]   mdiv_word;
  logic [31:0]   ctrl_now;
  logic [FW-1:0] fin;
  logic [FW-1:0] ftarget;
  logic          us_tick;
  logic          pll_lock;
  logic          wr_valid;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          done;
  logic          error;
  logic [FW-1:0] mult;

  pll_reprog_seq #(
    .FW(FW), .AW(AW), .STAT_ADDR(BASE), .MULT_MAX(32768),
    .WAIT_TICKS(WAITT), .TRIES(TRIES)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mdiv_word(mdiv_word),
    .ctrl_now(ctrl_now), .fin(fin), .ftarget(ftarget), .us_tick(us_tick),
    .pll_lock(pll_lock), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .error(error),
    .mult(mult)
  );

  int nchk = 0;
  int nerr = 0;

  // monitor state
  int          cyc = 0;
  int          cur_lock = 0;
  logic        cur_stall = 1'b0;
  logic        pu_seen = 1'b0;
  logic        pend = 1'b0;
  int          tcnt = 0;
  int          exp_end = -1;
  int          nw = 0;
  int          done_total = 0;
  int          stray_err = 0;
  int          last_nw = 0;
  logic        last_err = 1'b0;
  logic [31:0] last_mult = '0;
  int          last_done_cyc = 0;
  logic [AW-1:0] waddr [8];
  logic [31:0]   wdata [8];
  int            vcyc  [8];

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wdata(input logic [31:0] c, input logic [31:0] m, input int k);
    case (k)
      0:       return {c[31:5], 5'b00001};
      1:       return m;
      2:       return 32'h0030_2062;
      3:       return {c[31:5], 5'b00000};
      default: return {c[31:5], 5'b10000};
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_waddr(input int k);
    case (k)
      1:       return A_MUL;
      2:       return A_NP;
      default: return A_CTRL;
    endcase
  endfunction

  // Port driver and observer, acting half a cycle away from the active edge
  initial begin
    wr_ready = 1'b1;
    us_tick  = 1'b0;
    pll_lock = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      wr_ready = cur_stall ? cyc[0] : 1'b1;
      us_tick  = ((cyc % TICK_GAP) == 0);
      if (pu_seen && us_tick) begin
        tcnt++;
        if (cur_lock != 0 && tcnt == WAITT * cur_lock) exp_end = cyc + 1;
        if (cur_lock == 0 && tcnt == WAITT * TRIES) exp_end = cyc + 1;
      end
      pll_lock = (cur_lock != 0) && pu_seen && (tcnt >= WAITT * cur_lock);
      if (wr_valid && nw < 8) begin
        if (!pend) begin
          vcyc[nw] = cyc;
          pend = 1'b1;
        end
        if (wr_ready) begin
          waddr[nw] = wr_addr;
          wdata[nw] = wr_data;
          nw++;
          pend = 1'b0;
          if (nw == 4) begin
            pu_seen = 1'b1;
            tcnt = 0;
          end
        end
      end
      if (error && !done) stray_err++;
      if (done) begin
        done_total++;
        last_err = error;
        last_mult = mult;
        last_nw = nw;
        last_done_cyc = cyc;
        nw = 0;
        pend = 1'b0;
        pu_seen = 1'b0;
      end
    end
  end

  task automatic wait_done(input int snap);
    int wd = 0;
    while (done_total == snap && wd < RUN_LIMIT) begin
      @(posedge clk);
      wd++;
    end
    chk(wd < RUN_LIMIT, "R12 run completes (watchdog)", 64'(wd), 64'(RUN_LIMIT));
    repeat (3) @(posedge clk);
  endtask

  task automatic judge(input vec_t v, input logic [31:0] c, input int snap);
    chk(last_err == v.exp_err, "R2 R3 R9 R10 error flag", 64'(last_err), 64'(v.exp_err));
    chk(last_mult == v.exp_mult, "R3 multiplier", 64'(last_mult), 64'(v.exp_mult));
    chk(last_nw == int'(v.exp_nw), "R2 R3 R10 write count", 64'(last_nw), 64'(v.exp_nw));
    chk(done_total == snap + 1, "R12 one done pulse", 64'(done_total), 64'(snap + 1));
    for (int k = 0; k < int'(v.exp_nw) && k < last_nw; k++) begin
      chk(waddr[k] == exp_waddr(k), "R4 R5 R6 R9 write address", 64'(waddr[k]), 64'(exp_waddr(k)));
      chk(wdata[k] == exp_wdata(c, v.mdiv, k), "R4 R5 R6 R9 write data",
          64'(wdata[k]), 64'(exp_wdata(c, v.mdiv, k)));
    end
    if (v.exp_nw == 4'd5 && last_nw == 5)
      chk(vcyc[4] == exp_end, "R8 lock sample timing", 64'(vcyc[4]), 64'(exp_end));
    if (v.lock_at == 4'd0)
      chk(last_done_cyc == exp_end, "R10 error timing", 64'(last_done_cyc), 64'(exp_end));
    // R7: consecutive writes with ready held high
    if (!v.stall && last_nw >= 4)
      chk(vcyc[3] == vcyc[0] + 3, "R7 back-to-back writes", 64'(vcyc[3]), 64'(vcyc[0] + 3));
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int snap;
    v = VECS[i];
    @(negedge clk);
    cur_lock  = int'(v.lock_at);
    cur_stall = v.stall;
    fin       = v.fin;
    ftarget   = v.ft;
    ctrl_now  = v.ctrl;
    mdiv_word = v.mdiv;
    snap      = done_total;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    wait_done(snap);
    judge(v, v.ctrl, snap);
  endtask

  // R11: a second start mid-run with different inputs is ignored
  task automatic run_busy_start();
    vec_t v;
    int snap;
    v = VECS[0];
    @(negedge clk);
    cur_lock  = int'(v.lock_at);
    cur_stall = 1'b0;
    fin       = v.fin;
    ftarget   = v.ft;
    ctrl_now  = v.ctrl;
    mdiv_word = v.mdiv;
    snap      = done_total;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    repeat (5) @(negedge clk);
    fin       = 32'd50;
    ftarget   = 32'd60;
    ctrl_now  = 32'hFFFF_FFFF;
    mdiv_word = 32'h5555_5555;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    wait_done(snap);
    judge(v, v.ctrl, snap);
    chk(last_err == 1'b0, "R11 busy start ignored", 64'(last_err), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL global watchdog actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    start     = 1'b0;
    fin       = '0;
    ftarget   = '0;
    ctrl_now  = '0;
    mdiv_word = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(!wr_valid, "R1 wr_valid at reset", 64'(wr_valid), 64'd0);
    chk(!done, "R1 done at reset", 64'(done), 64'd0);
    chk(!error, "R1 error at reset", 64'(error), 64'd0);
    chk(mult == '0, "R1 mult at reset", 64'(mult), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    run_busy_start();

    chk(stray_err == 0, "R12 error only with done", 64'(stray_err), 64'd0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule